// File: doc/BRIEF.md
# Video Switch Control Register Target (serial two-wire, write-only)

This block is a write-only target on a two-wire serial control bus (I2C). It owns the control state of a multi-input video switch: two composite outputs that pick one of seven inputs or mute, and one component output set (three channels switched together) that picks one of three inputs or mutes. The registers' select fields come out as one-hot enables, and the power-save field comes out as a state flag. An external pin can force normal operation.

The bus lines reach the block as raw levels sampled by the system clock. Each line goes through a two-flop synchronizer and a glitch filter before the framing logic sees it. A frame addresses the device, then sets a register pointer, then writes one or more data bytes. After each data byte the pointer alternates between the two registers. Read addressing is refused and gets no acknowledge.

Top module: `vsw_i2c_ctrl`

## Requirements
- R1: After reset both registers hold zero. Every enable vector shows mute (bit 0 set, all other bits clear), and `power_save_o` is 1 while the pin is low.
- R2: Only the address byte 0x96 (7-bit address 0x4B, write) is acknowledged by pulling SDA low during the ninth clock. Any other write address gets no acknowledge and changes no register.
- R3: An address byte with the read bit set (0x97) is not acknowledged. Every clock after it, up to the next START, is ignored: no acknowledge and no register change.
- R4: A frame is START, address byte, pointer byte, then data bytes, each sent MSB first and each followed by an acknowledge slot. Register 0 bits [7:5] choose composite output 1 and bits [4:2] choose composite output 2. Code 0 is mute and codes 1 to 7 pick inputs 1 to 7. The decode is one-hot: bit n of the 8-bit enable is set for code n.
- R5: Register 1 bits [7:6] choose the component output set. Code 0 is mute and codes 1 to 3 pick inputs 1 to 3. The enable is the 4-bit one-hot vector with bit n set for code n. Bits [5:0] of register 1 and bit 0 of register 0 have no effect.
- R6: Bit 0 of the pointer byte selects the first register; its upper bits are ignored. After each data byte the pointer toggles (0, 1, 0, ...), so a third data byte lands in the same register as the first.
- R7: While the power-save pin is low, `power_save_o` equals the inverse of register 0 bit 1 (0 = save, 1 = normal).
- R8: While the power-save pin is high, `power_save_o` is 0 whatever register 0 bit 1 holds.
- R9: The new value of a data byte appears on the enable outputs while its acknowledge is being driven, before the ninth SCL rise.
- R10: A repeated START or a STOP in the middle of a byte discards the partial byte and leaves both registers unchanged.
- R11: A pulse shorter than the filter length (default 3 system clocks) on SCL or SDA is ignored: it neither clocks a bit nor forms a START or STOP.
- R12: The block works at SCL rates of 100 kHz and 400 kHz with zero data hold time. SDA is taken at the filtered SCL rise, so it may change in the same instant that SCL falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw bus clock level |
| sda_i | input | 1 | Raw bus data level (the wired line) |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain acknowledge) |
| ps_pin_i | input | 1 | Power-save override pin; high forces normal mode |
| cv1_sel_o | output | 8 | One-hot enable for composite output 1 (bit 0 = mute) |
| cv2_sel_o | output | 8 | One-hot enable for composite output 2 (bit 0 = mute) |
| comp_sel_o | output | 4 | One-hot enable for the component set (bit 0 = mute) |
| power_save_o | output | 1 | 1 = power-save mode active |

## Verification
The hardest cases to reach from the ports are the ones where the bus is cut off mid-byte or disturbed by sub-filter glitches. In those cases the registers must stay unchanged even though the shift register is partly loaded. The bench builds such frames bit by bit: it sends a few bits of a data byte, then issues a repeated START or a STOP. It also injects 30 ns pulses on SCL during its low phase and on SDA during its high phase inside live frames. Each case is then checked against a register model kept in the bench. For the acknowledge-time update, the bench samples the enables in the low phase of the ninth clock, before its rising edge.

// File: rtl/vsw_ctrl_pkg.sv
`timescale 1ns/1ps
package vsw_ctrl_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned CV_OUTS     = 2;
  localparam int unsigned CV_CODE_W   = 3;
  localparam int unsigned CV_SEL_W    = 1 << CV_CODE_W;
  localparam int unsigned COMP_CODE_W = 2;
  localparam int unsigned COMP_SEL_W  = 1 << COMP_CODE_W;
  localparam int unsigned PS_BIT      = 1;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_ADDR,
    RX_PTR,
    RX_DATA,
    RX_SKIP
  } rx_state_e;
endpackage

// File: rtl/i2c_line_filter.sv
`timescale 1ns/1ps
module i2c_line_filter #(
  parameter int unsigned FILT_CYC = 3,
  parameter logic        RST_LVL  = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CNT_W = $clog2(FILT_CYC + 1);

  logic             s1_q, s2_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= RST_LVL;
      s2_q   <= RST_LVL;
      cnt_q  <= '0;
      line_o <= RST_LVL;
    end else begin
      s1_q <= line_i;
      s2_q <= s1_q;
      if (s2_q != line_o) begin
        if (cnt_q == CNT_W'(FILT_CYC - 1)) begin
          line_o <= s2_q;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  // filtered level never toggles on two consecutive cycles
  p_min_width_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(line_o) |=> $stable(line_o));
endmodule

// File: rtl/vsw_i2c_rx.sv
`timescale 1ns/1ps
module vsw_i2c_rx
  import vsw_ctrl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR7 = 7'h4B
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic              wr_en_o,
  output logic              wr_ptr_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam logic [BYTE_W-1:0] ADDR_WR = {DEV_ADDR7, 1'b0};
  localparam int unsigned       BIT_W   = $clog2(BYTE_W + 1);

  rx_state_e         state_q;
  logic              scl_q, sda_q, ack_q, ptr_q;
  logic [BIT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] shift_q;
  logic              scl_rise, scl_fall, start_det, stop_det, byte_done, rx_active;

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
  assign byte_done = scl_fall && (bit_cnt_q == BIT_W'(BYTE_W));
  assign rx_active = (state_q == RX_ADDR) || (state_q == RX_PTR) || (state_q == RX_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= RX_IDLE;
      bit_cnt_q <= '0;
      shift_q   <= '0;
      ack_q     <= 1'b0;
      ptr_q     <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_ptr_o  <= 1'b0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_det) begin
        state_q   <= RX_ADDR;
        bit_cnt_q <= '0;
        ack_q     <= 1'b0;
      end else if (stop_det) begin
        state_q   <= RX_IDLE;
        bit_cnt_q <= '0;
        ack_q     <= 1'b0;
      end else if (rx_active) begin
        if (ack_q) begin
          if (scl_fall) ack_q <= 1'b0;
        end else if (scl_rise && bit_cnt_q < BIT_W'(BYTE_W)) begin
          shift_q   <= {shift_q[BYTE_W-2:0], sda_i};
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end else if (byte_done) begin
          bit_cnt_q <= '0;
          unique case (state_q)
            RX_ADDR: begin
              if (shift_q == ADDR_WR) begin
                ack_q   <= 1'b1;
                state_q <= RX_PTR;
              end else begin
                state_q <= RX_SKIP;
              end
            end
            RX_PTR: begin
              ptr_q   <= shift_q[0];
              ack_q   <= 1'b1;
              state_q <= RX_DATA;
            end
            default: begin
              ack_q     <= 1'b1;
              wr_en_o   <= 1'b1;
              wr_ptr_o  <= ptr_q;
              wr_data_o <= shift_q;
              ptr_q     <= ~ptr_q;
            end
          endcase
        end
      end
    end
  end

  assign sda_pull_o = ack_q;

  p_ack_scl_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_o) |-> !scl_i);
  p_skip_silent_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_SKIP) |-> !sda_pull_o);
  p_write_no_stop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(state_q) == RX_DATA);
endmodule

// File: rtl/vsw_ctrl_regs.sv
`timescale 1ns/1ps
module vsw_ctrl_regs
  import vsw_ctrl_pkg::*;
(
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic                              wr_ptr_i,
  input  logic [BYTE_W-1:0]                 wr_data_i,
  input  logic                              ps_pin_i,
  output logic [CV_OUTS-1:0][CV_SEL_W-1:0]  cv_sel_o,
  output logic [COMP_SEL_W-1:0]             comp_sel_o,
  output logic                              power_save_o
);
  logic [CV_OUTS-1:0][CV_CODE_W-1:0] cv_code_q;
  logic [COMP_CODE_W-1:0]            comp_code_q;
  logic                              run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      comp_code_q <= '0;
    end else if (wr_en_i) begin
      if (!wr_ptr_i) run_q <= wr_data_i[PS_BIT];
      else           comp_code_q <= wr_data_i[BYTE_W-1 -: COMP_CODE_W];
    end
  end

  for (genvar k = 0; k < CV_OUTS; k++) begin : g_cv
    localparam int unsigned MSB = BYTE_W - 1 - k * CV_CODE_W;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   cv_code_q[k] <= '0;
      else if (wr_en_i && !wr_ptr_i) cv_code_q[k] <= wr_data_i[MSB -: CV_CODE_W];
    end

    always_comb begin
      cv_sel_o[k] = '0;
      cv_sel_o[k][cv_code_q[k]] = 1'b1;
    end

    p_cv_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(cv_sel_o[k]) == 1);
  end

  always_comb begin
    comp_sel_o = '0;
    comp_sel_o[comp_code_q] = 1'b1;
  end

  assign power_save_o = ~ps_pin_i & ~run_q;

  p_comp_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(comp_sel_o) == 1);
  p_pin_override_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ps_pin_i |-> !power_save_o);
  p_hold_no_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(cv_sel_o) && $stable(comp_sel_o));
endmodule

// File: rtl/vsw_i2c_ctrl.sv
`timescale 1ns/1ps
module vsw_i2c_ctrl
  import vsw_ctrl_pkg::*;
#(
  parameter int unsigned FILT_CYC  = 3,
  parameter logic [6:0]  DEV_ADDR7 = 7'h4B
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_pull_o,
  input  logic                  ps_pin_i,
  output logic [CV_SEL_W-1:0]   cv1_sel_o,
  output logic [CV_SEL_W-1:0]   cv2_sel_o,
  output logic [COMP_SEL_W-1:0] comp_sel_o,
  output logic                  power_save_o
);
  localparam int unsigned NUM_LINES = 3;
  localparam logic [NUM_LINES-1:0] LINE_RST = 3'b011;

  logic [NUM_LINES-1:0]              raw_lines, flt_lines;
  logic                              wr_en, wr_ptr;
  logic [BYTE_W-1:0]                 wr_data;
  logic [CV_OUTS-1:0][CV_SEL_W-1:0]  cv_sel;

  assign raw_lines = {ps_pin_i, sda_i, scl_i};

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    i2c_line_filter #(
      .FILT_CYC(FILT_CYC),
      .RST_LVL (LINE_RST[g])
    ) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw_lines[g]),
      .line_o(flt_lines[g])
    );
  end

  vsw_i2c_rx #(.DEV_ADDR7(DEV_ADDR7)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (flt_lines[0]),
    .sda_i     (flt_lines[1]),
    .sda_pull_o(sda_pull_o),
    .wr_en_o   (wr_en),
    .wr_ptr_o  (wr_ptr),
    .wr_data_o (wr_data)
  );

  vsw_ctrl_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wr_ptr_i    (wr_ptr),
    .wr_data_i   (wr_data),
    .ps_pin_i    (flt_lines[2]),
    .cv_sel_o    (cv_sel),
    .comp_sel_o  (comp_sel_o),
    .power_save_o(power_save_o)
  );

  assign cv1_sel_o = cv_sel[0];
  assign cv2_sel_o = cv_sel[1];

  // selections only move while an acknowledge is on the line
  p_update_in_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({cv1_sel_o, cv2_sel_o, comp_sel_o}) |-> sda_pull_o);
endmodule

// File: tb/vsw_i2c_ctrl_test.sv
`timescale 1ns/1ps
module vsw_i2c_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       ps_pin = 1'b0;
  logic       sda_line;
  logic       sda_pull;
  logic [7:0] cv1, cv2;
  logic [3:0] comp;
  logic       psave;

  int errors = 0;
  int checks = 0;
  int half_ns = 1250;
  int glitch_mode = 0;
  bit done = 1'b0;
  logic [7:0] m0 = 8'h00, m1 = 8'h00;

  always #10 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  vsw_i2c_ctrl uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (scl),
    .sda_i       (sda_line),
    .sda_pull_o  (sda_pull),
    .ps_pin_i    (ps_pin),
    .cv1_sel_o   (cv1),
    .cv2_sel_o   (cv2),
    .comp_sel_o  (comp),
    .power_save_o(psave)
  );

  // {addr, ptr, d0, d1, d2, count}
  localparam int NV = 8;
  localparam logic [47:0] VEC [NV] = '{
    48'h96_00_A4_00_00_01,
    48'h96_01_80_00_00_01,
    48'h96_00_FE_40_00_02,
    48'h96_01_C0_24_00_02,
    48'h94_00_FF_FF_00_02,
    48'h97_00_FF_C0_00_02,
    48'h96_03_00_3A_00_02,
    48'h96_00_48_C2_6E_03
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; #(half_ns);
    scl = 1'b1;   #(half_ns);
    sda_m = 1'b0; #(half_ns);
    scl = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; #(half_ns);
    scl = 1'b1;   #(half_ns);
    sda_m = 1'b1; #(half_ns);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i];
      #(half_ns / 2);
      if (glitch_mode == 1 && i == 4) begin scl = 1'b1; #30; scl = 1'b0; #(half_ns / 2 - 30); end
      else #(half_ns / 2);
      scl = 1'b1;
      #(half_ns / 2);
      if (glitch_mode == 2 && i == 4 && b[i]) begin sda_m = 1'b0; #30; sda_m = 1'b1; #(half_ns / 2 - 30); end
      else #(half_ns / 2);
      scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked, output logic [19:0] snap);
    send_bits(b, 8);
    sda_m = 1'b1;
    #(half_ns);
    snap = {cv1, cv2, comp};
    scl = 1'b1;
    #(half_ns / 2);
    acked = ~sda_line;
    #(half_ns / 2);
    scl = 1'b0;
  endtask

  function automatic logic [19:0] expect_sel();
    return {8'b1 << m0[7:5], 8'b1 << m0[4:2], 4'b1 << m1[7:6]};
  endfunction

  task automatic model_write(input logic [7:0] ptr, input logic [7:0] d [3], input int n);
    logic p = ptr[0];
    for (int j = 0; j < n; j++) begin
      if (!p) m0 = d[j]; else m1 = d[j];
      p = ~p;
    end
  endtask

  task automatic check_outputs(input string req);
    logic [19:0] e = expect_sel();
    logic        ep = ~ps_pin & ~m0[1];
    chk({cv1, cv2, comp} == e, req, {12'h0, cv1, cv2, comp}, {12'h0, e});
    chk(psave == ep, req, {31'h0, psave}, {31'h0, ep});
  endtask

  task automatic run_frame(input logic [7:0] a, input logic [7:0] p, input logic [7:0] d [3],
                           input int n, output bit addr_ack);
    bit          ak;
    logic [19:0] sn;
    bus_start();
    send_byte(a, addr_ack, sn);
    send_byte(p, ak, sn);
    for (int j = 0; j < n; j++) send_byte(d[j], ak, sn);
    bus_stop();
  endtask

  initial begin
    bit          ack;
    logic [7:0]  d [3];
    logic [19:0] sn;
    #105 rst_n = 1'b1;
    #200;
    // R1 reset state
    chk(cv1 == 8'h01, "R1", {24'h0, cv1}, 32'h01);
    chk(cv2 == 8'h01, "R1", {24'h0, cv2}, 32'h01);
    chk(comp == 4'h1, "R1", {28'h0, comp}, 32'h1);
    chk(psave == 1'b1, "R1", {31'h0, psave}, 32'h1);

    // table: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      logic [47:0] e = VEC[v];
      d[0] = e[31:24]; d[1] = e[23:16]; d[2] = e[15:8];
      run_frame(e[47:40], e[39:32], d, int'(e[7:0]), ack);
      if (e[47:40] == 8'h96) model_write(e[39:32], d, int'(e[7:0]));
      chk(ack == (e[47:40] == 8'h96), "R2/R3 address ack", {31'h0, ack}, {31'h0, e[47:40] == 8'h96});
      #1000;
      check_outputs("R4/R5/R6/R7 table");
    end

    // R8 pin override
    d[0] = 8'h00; d[1] = 8'h00; d[2] = 8'h00;
    run_frame(8'h96, 8'h00, d, 1, ack);
    model_write(8'h00, d, 1);
    #400;
    chk(psave == 1'b1, "R7 save bit", {31'h0, psave}, 32'h1);
    ps_pin = 1'b1; #400;
    chk(psave == 1'b0, "R8 pin high", {31'h0, psave}, 32'h0);
    ps_pin = 1'b0; #400;
    chk(psave == 1'b1, "R8 pin low", {31'h0, psave}, 32'h1);

    // R9 value visible during the data byte acknowledge
    bus_start();
    send_byte(8'h96, ack, sn);
    send_byte(8'h00, ack, sn);
    send_byte(8'h9C, ack, sn);
    m0 = 8'h9C;
    chk(sn == expect_sel(), "R9 ack-time update", {12'h0, sn}, {12'h0, expect_sel()});
    bus_stop();
    #400;

    // R10 repeated START mid-byte, then STOP mid-byte
    bus_start();
    send_byte(8'h96, ack, sn);
    send_byte(8'h00, ack, sn);
    send_bits(8'hFF, 4);
    bus_start();
    send_byte(8'h96, ack, sn);
    send_byte(8'h01, ack, sn);
    send_bits(8'hFF, 5);
    bus_stop();
    #1000;
    check_outputs("R10 partial byte");

    // R11 glitches on SCL (low phase) and SDA (high phase)
    glitch_mode = 1;
    d[0] = 8'hB6;
    run_frame(8'h96, 8'h00, d, 1, ack);
    model_write(8'h00, d, 1);
    #1000;
    check_outputs("R11 scl glitch");
    glitch_mode = 2;
    d[0] = 8'hDF;
    run_frame(8'h96, 8'h01, d, 1, ack);
    model_write(8'h01, d, 1);
    #1000;
    check_outputs("R11 sda glitch");
    glitch_mode = 0;

    // R12 100 kHz frame
    half_ns = 5000;
    d[0] = 8'h5C; d[1] = 8'h80;
    run_frame(8'h96, 8'h00, d, 2, ack);
    model_write(8'h00, d, 2);
    chk(ack == 1'b1, "R12 slow ack", {31'h0, ack}, 32'h1);
    #1000;
    check_outputs("R12 slow rate");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #3_500_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule